// File: doc/BRIEF.md
# Eight-Input Cascadable Interrupt Controller

This block gathers up to eight interrupt inputs and presents one request to a processor. When the processor acknowledges, the block returns a vector. Software sets it up through a byte-wide port with two addresses. A write to the control address with bit 4 set begins a short series of data-address words. These words set the vector base and the cascade wiring, and an optional mode word may follow. After that series, the data address carries the interrupt mask.

A separate trigger register picks edge or level sensing for each input. Priority is fixed, with input 0 the most urgent. An in-service register keeps nested handlers in order, and a control write of 0x20 retires the most urgent handler.

Several instances can be chained. The strap `master_i` marks the master. On the master, the third setup word lists which inputs carry a slave. On a slave, that word holds the slave's own 3-bit number. When an acknowledged input on the master has a slave behind it, the master puts the input number on `cas_o`, and only the slave whose number matches supplies the vector.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service register reads 0x00, the trigger register is 0x00, `int_o` is low and the setup sequencer is idle.
- R2: A control write with bit 4 set clears the mask, the in-service register and any latched edge requests, then starts the setup sequence. Bit 0 of that byte = 1 means a mode word ends the sequence. Bit 1 = 1 means single mode, which skips the cascade word.
- R3: The first data write after a setup start sets the vector base from bits 7:3. Bits 2:0 of that write are ignored.
- R4: While the setup sequence runs, data writes do not change the mask. Once it is idle, a data write loads the mask. A read at address 1 returns the mask and a read at address 0 returns the in-service register.
- R5: An input whose mask bit is 1 never drives `int_o` and is never acknowledged. A request latched while the input was masked is served once the input is unmasked.
- R6: The trigger register is written through `trig_wr_i` and shown on `trig_o`, with 1 = level and 0 = edge. Neither the mask nor the setup sequence changes it.
- R7: An edge-mode input latches a request on a rising edge. The request stays pending after the input falls, until it is acknowledged.
- R8: A level-mode input requests only while it is high. Dropping it withdraws the request. If it is still high after its handler is retired, it requests again.
- R9: The pending unmasked input with the lowest index wins. One cycle after `inta_i`, `vec_vld_o` pulses and `vec_o` equals base*8 + the winning index. That input's bit is set in the in-service register.
- R10: A request is forwarded only if its index is lower than every bit currently in service.
- R11: A control write of 0x20 clears the lowest set in-service bit. If it lands in the same cycle as an acknowledge, the bit is cleared and the new bit is set together.
- R12: On a master whose winning input is marked in the cascade word (not in single mode), `cas_o` carries that index and the master gives no vector. A slave answers `inta_i` only when `cas_i` equals its own number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master, 0 = slave |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control, 1 = data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| trig_wr_i | input | 1 | Trigger register write strobe |
| trig_wdata_i | input | 8 | Trigger register write data |
| trig_o | output | 8 | Trigger register (1 = level) |
| irq_i | input | 8 | Interrupt inputs |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge pulse |
| cas_i | input | 3 | Cascade number seen by a slave |
| cas_o | output | 3 | Cascade number driven by a master |
| vec_vld_o | output | 1 | Vector valid pulse |
| vec_o | output | 8 | Delivered vector |

## Verification
Retiring a handler and accepting a new interrupt can both hit the in-service register in the same cycle. To provoke this, the bench first leaves input 3 in service. It then raises input 1, which outranks 3, and drives `inta_i` and a 0x20 control write on the same clock edge. The result is judged at the ports: the vector must be for input 1, and the in-service read must show bit 1 set and bit 3 clear. Losing either update gives a wrong read value.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_CASC, ST_MODE} icw_st_e;
  localparam logic [2:0] OP_EOI_HI = 3'b001;
endpackage

// File: rtl/pic8_icw_seq.sv
module pic8_icw_seq
  import pic8_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [7:0]       wdata_i,
  output logic             init_o,
  output logic             eoi_o,
  output logic             single_o,
  output logic [N_IN-1:0]  mask_o,
  output logic [7-IDX_W:0] base_o,
  output logic [7:0]       casc_o
);
  icw_st_e st_q;
  logic    need_mode_q;
  logic    ctl_wr, dat_wr;

  assign ctl_wr = wr_i & ~addr_i;
  assign dat_wr = wr_i & addr_i;
  assign init_o = ctl_wr & wdata_i[4];
  assign eoi_o  = ctl_wr & (st_q == ST_IDLE) & (wdata_i[7:5] == OP_EOI_HI) & ~wdata_i[4] & ~wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      need_mode_q <= 1'b0;
      single_o    <= 1'b1;
      mask_o      <= '1;
      base_o      <= '0;
      casc_o      <= '0;
    end else if (init_o) begin
      st_q        <= ST_BASE;
      need_mode_q <= wdata_i[0];
      single_o    <= wdata_i[1];
      mask_o      <= '0;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_IDLE: mask_o <= wdata_i[N_IN-1:0];
        ST_BASE: begin
          base_o <= wdata_i[7:IDX_W];
          st_q   <= !single_o ? ST_CASC : (need_mode_q ? ST_MODE : ST_IDLE);
        end
        ST_CASC: begin
          casc_o <= wdata_i;
          st_q   <= need_mode_q ? ST_MODE : ST_IDLE;
        end
        ST_MODE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && !init_o && st_q != ST_IDLE) |=> $stable(mask_o));
endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
  parameter int N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] irq_i,
  input  logic            trig_wr_i,
  input  logic [N_IN-1:0] trig_wdata_i,
  input  logic            clr_i,
  input  logic [N_IN-1:0] ack_i,
  output logic [N_IN-1:0] trig_o,
  output logic [N_IN-1:0] req_o
);
  logic [N_IN-1:0] irq_q, edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      edge_q <= '0;
      trig_o <= '0;
    end else begin
      irq_q  <= irq_i;
      edge_q <= clr_i ? '0 : ((edge_q & ~ack_i) | (irq_i & ~irq_q));
      if (trig_wr_i) trig_o <= trig_wdata_i;
    end
  end

  assign req_o = (trig_o & irq_q) | (~trig_o & edge_q);

  // R7
  edge_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_q & ~$past(edge_q) & ~$past(irq_i)) == '0));
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  req_i,
  input  logic [N_IN-1:0]  mask_i,
  input  logic [N_IN-1:0]  isr_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [N_IN-1:0]  win_oh_o,
  output logic [N_IN-1:0]  isr_top_o
);
  logic [N_IN-1:0] pend, pend_oh;

  assign pend      = req_i & ~mask_i;
  assign pend_oh   = pend & (~pend + N_IN'(1));
  assign isr_top_o = isr_i & (~isr_i + N_IN'(1));
  // bits strictly below the top in-service bit; all ones when nothing is in service
  assign win_oh_o  = pend_oh & (isr_top_o - N_IN'(1));
  assign win_vld_o = |win_oh_o;

  always_comb begin
    win_idx_o = '0;
    for (int i = 0; i < N_IN; i++)
      if (win_oh_o[i]) win_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
  parameter int N_IN  = 8,
  parameter int CAS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             trig_wr_i,
  input  logic [N_IN-1:0]  trig_wdata_i,
  output logic [N_IN-1:0]  trig_o,
  input  logic [N_IN-1:0]  irq_i,
  output logic             int_o,
  input  logic             inta_i,
  input  logic [CAS_W-1:0] cas_i,
  output logic [CAS_W-1:0] cas_o,
  output logic             vec_vld_o,
  output logic [7:0]       vec_o
);
  localparam int IDX_W = $clog2(N_IN);

  logic             init, eoi, single;
  logic [N_IN-1:0]  mask_q, req, win_oh, isr_top, ack_oh;
  logic [N_IN-1:0]  isr_q;
  logic [7-IDX_W:0] base_q;
  logic [7:0]       casc_q;
  logic             win_vld, casc_hit, respond;
  logic [IDX_W-1:0] win_idx;

  pic8_icw_seq #(.N_IN(N_IN), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .init_o(init), .eoi_o(eoi), .single_o(single),
    .mask_o(mask_q), .base_o(base_q), .casc_o(casc_q)
  );

  pic8_req #(.N_IN(N_IN)) u_req (
    .clk_i, .rst_ni, .irq_i, .trig_wr_i, .trig_wdata_i,
    .clr_i(init), .ack_i(ack_oh), .trig_o, .req_o(req)
  );

  pic8_prio #(.N_IN(N_IN), .IDX_W(IDX_W)) u_prio (
    .req_i(req), .mask_i(mask_q), .isr_i(isr_q),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_oh_o(win_oh), .isr_top_o(isr_top)
  );

  assign casc_hit = master_i & ~single & casc_q[win_idx];
  assign respond  = inta_i & win_vld &
                    (master_i | single | (cas_i == casc_q[CAS_W-1:0]));
  assign ack_oh   = respond ? win_oh : '0;
  assign int_o    = win_vld;
  assign cas_o    = (win_vld & casc_hit) ? CAS_W'(win_idx) : '0;
  assign rdata_o  = addr_i ? 8'(mask_q) : 8'(isr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q     <= '0;
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
    end else begin
      isr_q     <= init ? '0 : ((isr_q & ~(eoi ? isr_top : '0)) | ack_oh);
      vec_vld_o <= respond & ~casc_hit;
      if (respond) vec_o <= {base_q, win_idx};
    end
  end

  // R9
  vec_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(inta_i));
  // R2
  init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init |=> (mask_q == '0 && isr_q == '0));
  // R11
  eoi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !respond && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // R10
  nest_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (respond && !eoi && !init) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));
  // R5
  mask_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    respond |=> ((isr_q & ~$past(isr_q) & $past(mask_q)) == '0));
  // R12
  cas_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_o != '0) |-> (master_i && int_o));
endmodule

// File: tb/pic8_ctrl_tb.sv
`timescale 1ns/1ps
module pic8_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_wr = 0, s_wr = 0, addr = 0, inta = 0, m_trig_wr = 0;
  logic [7:0] wdata = 0, trig_wdata = 0, m_irq_in = 0, s_irq = 0;
  logic [7:0] m_rdata, s_rdata, m_trig, s_trig, m_vec, s_vec, m_irq;
  logic m_int, s_int, m_vld, s_vld;
  logic [2:0] m_cas, s_cas_o;
  int checks = 0, bad = 0;

  always #2 clk = ~clk;

  assign m_irq = {m_irq_in[7:3], s_int, m_irq_in[1:0]};

  pic8_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1), .wr_i(m_wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(m_rdata), .trig_wr_i(m_trig_wr), .trig_wdata_i(trig_wdata),
    .trig_o(m_trig), .irq_i(m_irq), .int_o(m_int), .inta_i(inta), .cas_i(3'd0),
    .cas_o(m_cas), .vec_vld_o(m_vld), .vec_o(m_vec)
  );

  pic8_ctrl u_slv (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0), .wr_i(s_wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(s_rdata), .trig_wr_i(1'b0), .trig_wdata_i(8'h00),
    .trig_o(s_trig), .irq_i(s_irq), .int_o(s_int), .inta_i(inta), .cas_i(m_cas),
    .cas_o(s_cas_o), .vec_vld_o(s_vld), .vec_o(s_vec)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic slv, input logic a, input logic [7:0] d);
    @(negedge clk);
    if (slv) s_wr = 1; else m_wr = 1;
    addr = a; wdata = d;
    @(negedge clk);
    m_wr = 0; s_wr = 0;
  endtask

  task automatic rd(input logic slv, input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = slv ? s_rdata : m_rdata;
  endtask

  task automatic ack();
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, 1, d); chk("R1 mask", d, 8'hFF);
    rd(0, 0, d); chk("R1 isr", d, 8'h00);
    chk("R1 trig", m_trig, 0);
    chk("R1 int", m_int, 0);
  endtask

  task automatic t_init();
    logic [7:0] d;
    wr(0, 1, 8'h3C);
    wr(0, 0, 8'h11);
    rd(0, 1, d); chk("R2 mask cleared", d, 8'h00);
    wr(0, 1, 8'h6D);
    wr(0, 1, 8'h04);
    rd(0, 1, d); chk("R4 mask held in setup", d, 8'h00);
    wr(0, 1, 8'h01);
    wr(0, 1, 8'hA5);
    rd(0, 1, d); chk("R4 mask load", d, 8'hA5);
    wr(0, 1, 8'h00);
    wr(1, 0, 8'h11); wr(1, 1, 8'h70); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    rd(1, 1, d); chk("R2 slave mask", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(0, 1, 8'hFF);
    @(negedge clk); m_irq_in[5] = 1;
    tick(1); chk("R5 masked int", m_int, 0);
    m_irq_in[5] = 0;
    wr(0, 1, 8'hDF);
    chk("R5 unmasked int", m_int, 1);
    ack(); chk("R9 vld", m_vld, 1); chk("R3 vec", m_vec, 8'h6D);
    rd(0, 0, d); chk("R4 isr read", d, 8'h20);
    wr(0, 0, 8'h20);
    rd(0, 0, d); chk("R11 eoi", d, 8'h00);
    wr(0, 1, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    @(negedge clk); m_irq_in = 8'h0A;
    tick(1);
    ack(); chk("R9 prio vec", m_vec, 8'h69);
    tick(1); chk("R10 blocked", m_int, 0);
    m_irq_in[0] = 1;
    tick(1); chk("R10 higher passes", m_int, 1);
    ack(); chk("R9 vec0", m_vec, 8'h68);
    rd(0, 0, d); chk("R10 nested isr", d, 8'h03);
    wr(0, 0, 8'h20);
    rd(0, 0, d); chk("R11 top cleared", d, 8'h02);
    m_irq_in = 8'h00;
    wr(0, 0, 8'h20);
    tick(1); chk("R7 held edge", m_int, 1);
    ack(); chk("R7 vec3", m_vec, 8'h6B);
    wr(0, 0, 8'h20);
  endtask

  task automatic t_level();
    @(negedge clk); m_trig_wr = 1; trig_wdata = 8'h10;
    @(negedge clk); m_trig_wr = 0;
    chk("R6 trig", m_trig, 8'h10);
    m_irq_in[4] = 1;
    tick(1); chk("R8 level int", m_int, 1);
    m_irq_in[4] = 0;
    tick(1); chk("R8 withdrawn", m_int, 0);
    m_irq_in[4] = 1;
    tick(1);
    ack(); chk("R9 vec4", m_vec, 8'h6C);
    chk("R10 in service", m_int, 0);
    wr(0, 0, 8'h20);
    chk("R8 re-request", m_int, 1);
    m_irq_in[4] = 0;
    tick(2); chk("R8 off", m_int, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); m_irq_in[3] = 1;
    tick(1);
    ack();
    @(negedge clk); m_irq_in[1] = 1;
    tick(1); chk("R10 outranks", m_int, 1);
    inta = 1; m_wr = 1; addr = 0; wdata = 8'h20;
    @(negedge clk); inta = 0; m_wr = 0;
    chk("R11 collide vec", m_vec, 8'h69);
    rd(0, 0, d); chk("R11 collide isr", d, 8'h02);
    m_irq_in = 0;
    wr(0, 0, 8'h20);
  endtask

  task automatic t_cascade();
    logic [7:0] d;
    @(negedge clk); s_irq[3] = 1;
    tick(2); chk("R12 master int", m_int, 1);
    chk("R12 cas", m_cas, 2);
    ack();
    chk("R12 master quiet", m_vld, 0);
    chk("R12 slave vld", s_vld, 1);
    chk("R12 slave vec", s_vec, 8'h73);
    rd(0, 0, d); chk("R12 master isr", d, 8'h04);
    rd(1, 0, d); chk("R12 slave isr", d, 8'h08);
    wr(1, 0, 8'h20); wr(0, 0, 8'h20);
    s_irq = 0;
    wr(0, 1, 8'h04);
    @(negedge clk); s_irq[5] = 1; m_irq_in[5] = 1;
    tick(2); chk("R12 cas idle", m_cas, 0);
    ack();
    chk("R12 own vec", m_vec, 8'h6D);
    chk("R12 slave silent", s_vld, 0);
    rd(1, 0, d); chk("R12 slave isr idle", d, 8'h00);
    wr(0, 0, 8'h20);
    m_irq_in = 0; s_irq = 0;
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr(0, 0, 8'h13); wr(0, 1, 8'h47); wr(0, 1, 8'h01); wr(0, 1, 8'h81);
    rd(0, 1, d); chk("R2 single mask", d, 8'h81);
    chk("R6 trig kept", m_trig, 8'h10);
    @(negedge clk); m_irq_in[1] = 1;
    tick(1);
    ack(); chk("R3 low bits ignored", m_vec, 8'h41);
    m_irq_in = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_init();
    t_mask();
    t_prio();
    t_level();
    t_collide();
    t_cascade();
    t_single();
    tick(2);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule